// File: doc/BRIEF.md
# Serial Memory Slave Command Front End

This block is the serial-facing half of a byte-wide memory with a four-wire synchronous serial port. It runs on a fast system clock and oversamples the chip select, serial clock, serial data in and hold inputs. From these it rebuilds the instruction byte and the address, then acts on the instruction. For a read it streams bytes from a 512 x 8 synchronous array port, most significant bit first, and wraps from the last address back to the first. For a status read it returns a status byte supplied from outside. Writes, status writes and the two latch-control commands go to a separate write controller as one-cycle requests. The front end applies no write-enable or protection policy of its own.

The serial clock may idle low or idle high, so clock modes 0 and 3 both work. Serial data is taken on rising serial-clock edges and changes on falling ones. The output-enable pin marks when the serial output is driven. When it is low, the pad is at high impedance.

Top module: `spi_mem_front`

## Requirements
- R1: An instruction byte is valid only when bits 7:4 are zero. Bits 2:0 select the command: 110 write-enable, 100 write-disable, 101 status read, 001 status write, 011 array read, 010 array write. Bit 3 is address bit 8 for array read and array write and is ignored for the other commands.
- R2: All bytes travel most significant bit first. Serial input is taken on rising serial-clock edges and serial output changes on falling edges, with the clock idling either low or high.
- R3: An array read takes one address byte after the instruction. It then returns the byte at that address and the bytes at each following address while chip select stays low, wrapping from 0x1FF to 0x000.
- R4: An instruction byte that is not valid leaves so_oe_o low and raises no request or array read until the next falling edge of chip select.
- R5: While chip select is high, so_oe_o is low and serial input and clock activity have no effect. Each falling edge of chip select starts a new instruction.
- R6: While hold is low, so_oe_o is low and serial clock and data are ignored. Raising hold resumes the sequence where it stopped.
- R7: While wr_busy_i is high when an instruction completes, only status read is carried out. Any other instruction raises no request, makes no array read and leaves so_oe_o low.
- R8: A status read samples status_i at the start of every output byte and keeps returning bytes for as long as the clock runs.
- R9: Each data byte of an array write raises a request of kind 4 with the byte and its address. The three lowest address bits then step by one and wrap, and the upper bits stay fixed.
- R10: Write-enable raises a request of kind 1 and write-disable a request of kind 2. A status write raises a request of kind 3 carrying the first byte after the instruction. Later bytes are ignored.
- R11: req_valid_o and mem_rd_o are single-cycle pulses. Array data is expected one system cycle after mem_rd_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Hold, active low |
| so_o | output | 1 | Serial data out value |
| so_oe_o | output | 1 | Serial output drive enable (low means high impedance) |
| mem_rd_o | output | 1 | Array read strobe |
| mem_addr_o | output | 9 | Array read address |
| mem_rdata_i | input | 8 | Array read data, one cycle after the strobe |
| status_i | input | 8 | Status byte returned by status read |
| wr_busy_i | input | 1 | Internal write cycle in progress |
| req_valid_o | output | 1 | Request pulse to the write controller |
| req_kind_o | output | 3 | Request kind: 1 enable, 2 disable, 3 status write, 4 data write |
| req_addr_o | output | 9 | Address for a data write request |
| req_data_o | output | 8 | Data for a data or status write request |

## Verification
The assertions assume that wr_busy_i changes only while chip select is high. They also assume that hold and the serial clock change no faster than every few system cycles, so requests and array reads can never come back to back. The bench drives each serial half period as eight system cycles. It raises busy only between transactions and moves hold only while the serial clock is low. This keeps every input inside those assumptions while still covering both clock idle levels and a pause in the middle of a transfer.

// File: rtl/spi_mem_pkg.sv
`timescale 1ns/1ps
package spi_mem_pkg;
    localparam int ADDR_W    = 9;
    localparam int PAGE_BITS = 3;

    localparam logic [2:0] OP_WREN  = 3'b110;
    localparam logic [2:0] OP_WRDI  = 3'b100;
    localparam logic [2:0] OP_RDSR  = 3'b101;
    localparam logic [2:0] OP_WRSR  = 3'b001;
    localparam logic [2:0] OP_READ  = 3'b011;
    localparam logic [2:0] OP_WRITE = 3'b010;

    localparam logic [2:0] RQ_WREN  = 3'd1;
    localparam logic [2:0] RQ_WRDI  = 3'd2;
    localparam logic [2:0] RQ_WRSR  = 3'd3;
    localparam logic [2:0] RQ_WRITE = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_SEND, ST_RECV, ST_MUTE
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        logic [2:0]          bcnt;
        logic [7:0]          sh;
        logic [7:0]          osh;
        logic [ADDR_W-1:0]   addr;
        logic                is_rd;
        logic                is_sr;
        logic                is_wrsr;
        logic                so;
        logic                fetch;
        logic                ld;
        logic                req_v;
        logic [2:0]          req_k;
        logic [7:0]          req_d;
        logic [ADDR_W-1:0]   req_a;
        logic                cs_p;
        logic                sck_p;
    } core_s;
endpackage

// File: rtl/spi_mem_sync.sv
`timescale 1ns/1ps
module spi_mem_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stage_q[s] <= RST_VAL;
            else if (s == 0) stage_q[s] <= d_i;
            else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_mem_core.sv
`timescale 1ns/1ps
module spi_mem_core
    import spi_mem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    input  logic [7:0]        mem_rdata_i,
    input  logic [7:0]        status_i,
    input  logic              wr_busy_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              req_valid_o,
    output logic [2:0]        req_kind_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [7:0]        req_data_o
);
    core_s q, n;
    logic  cs_fall, sck_rise, sck_fall, rx_phase;
    logic [7:0] b;

    assign cs_fall  = q.cs_p & ~cs_n;
    assign sck_rise = ~q.sck_p & sck;
    assign sck_fall = q.sck_p & ~sck;
    assign rx_phase = (q.ph == ST_OPC) || (q.ph == ST_ADDR) || (q.ph == ST_RECV);
    assign b        = {q.sh[6:0], si};

    always_comb begin
        n       = q;
        n.fetch = 1'b0;
        n.ld    = q.fetch;
        n.req_v = 1'b0;
        n.cs_p  = cs_n;
        n.sck_p = sck;
        if (q.ld) n.osh = q.is_sr ? status_i : mem_rdata_i;

        if (cs_n) begin
            n.ph = ST_IDLE;
        end else if (cs_fall) begin
            n.ph   = ST_OPC;
            n.bcnt = '0;
        end else if (hold_n && sck_rise && rx_phase) begin
            n.sh   = b;
            n.bcnt = q.bcnt + 3'd1;
            if (q.bcnt == 3'd7) begin
                unique case (q.ph)
                    ST_OPC: begin
                        n.ph      = ST_MUTE;
                        n.is_rd   = 1'b0;
                        n.is_sr   = 1'b0;
                        n.is_wrsr = 1'b0;
                        if (b[7:4] == 4'd0 && (!wr_busy_i || b[2:0] == OP_RDSR)) begin
                            case (b[2:0])
                                OP_RDSR:  begin n.ph = ST_SEND; n.is_sr = 1'b1; n.ld = 1'b1; end
                                OP_WREN:  begin n.req_v = 1'b1; n.req_k = RQ_WREN; end
                                OP_WRDI:  begin n.req_v = 1'b1; n.req_k = RQ_WRDI; end
                                OP_WRSR:  begin n.ph = ST_RECV; n.is_wrsr = 1'b1; end
                                OP_READ:  begin n.ph = ST_ADDR; n.is_rd = 1'b1; n.addr[ADDR_W-1] = b[3]; end
                                OP_WRITE: begin n.ph = ST_ADDR; n.addr[ADDR_W-1] = b[3]; end
                                default:  ;
                            endcase
                        end
                    end
                    ST_ADDR: begin
                        n.addr[7:0] = b;
                        if (q.is_rd) begin
                            n.ph    = ST_SEND;
                            n.fetch = 1'b1;
                        end else begin
                            n.ph = ST_RECV;
                        end
                    end
                    default: begin
                        n.req_v = 1'b1;
                        n.req_d = b;
                        n.req_a = q.addr;
                        if (q.is_wrsr) begin
                            n.req_k = RQ_WRSR;
                            n.ph    = ST_MUTE;
                        end else begin
                            n.req_k = RQ_WRITE;
                            n.addr[PAGE_BITS-1:0] = q.addr[PAGE_BITS-1:0] + 1'b1;
                        end
                    end
                endcase
            end
        end else if (hold_n && sck_fall && q.ph == ST_SEND) begin
            n.so   = q.osh[7];
            n.osh  = {q.osh[6:0], 1'b0};
            n.bcnt = q.bcnt + 3'd1;
            if (q.bcnt == 3'd7) begin
                if (q.is_sr) begin
                    n.ld = 1'b1;
                end else begin
                    n.addr  = q.addr + 1'b1;
                    n.fetch = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ph    <= ST_IDLE;
            q.cs_p  <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign so_o        = q.so;
    assign so_oe_o     = (q.ph == ST_SEND) && !cs_n && hold_n;
    assign mem_rd_o    = q.fetch;
    assign mem_addr_o  = q.addr;
    assign req_valid_o = q.req_v;
    assign req_kind_o  = q.req_k;
    assign req_addr_o  = q.req_a;
    assign req_data_o  = q.req_d;
endmodule

// File: rtl/spi_mem_front.sv
`timescale 1ns/1ps
module spi_mem_front
    import spi_mem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              si_i,
    input  logic              hold_n_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_rdata_i,
    input  logic [7:0]        status_i,
    input  logic              wr_busy_i,
    output logic              req_valid_o,
    output logic [2:0]        req_kind_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [7:0]        req_data_o
);
    logic [3:0] pins_s;

    spi_mem_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n_i, sck_i, si_i, hold_n_i}),
        .q_o   (pins_s)
    );

    spi_mem_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (pins_s[3]),
        .sck         (pins_s[2]),
        .si          (pins_s[1]),
        .hold_n      (pins_s[0]),
        .mem_rdata_i (mem_rdata_i),
        .status_i    (status_i),
        .wr_busy_i   (wr_busy_i),
        .so_o        (so_o),
        .so_oe_o     (so_oe_o),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .req_valid_o (req_valid_o),
        .req_kind_o  (req_kind_o),
        .req_addr_o  (req_addr_o),
        .req_data_o  (req_data_o)
    );
endmodule

// File: rtl/spi_mem_front_chk.sv
`timescale 1ns/1ps
module spi_mem_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n_i,
    input logic       hold_n_i,
    input logic       so_oe_o,
    input logic       mem_rd_o,
    input logic       req_valid_o,
    input logic [2:0] req_kind_o,
    input logic       wr_busy_i
);
    p_idle_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !so_oe_o);

    p_hold_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n_i && !$past(hold_n_i) && !$past(hold_n_i, 2) && !$past(hold_n_i, 3)) |-> !so_oe_o);

    p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |=> !req_valid_o);

    p_rd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);

    p_busy_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> !wr_busy_i);

    p_busy_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> !wr_busy_i);

    p_kind_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_kind_o >= 3'd1 && req_kind_o <= 3'd4));
endmodule

bind spi_mem_front spi_mem_front_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_i      (cs_n_i),
    .hold_n_i    (hold_n_i),
    .so_oe_o     (so_oe_o),
    .mem_rd_o    (mem_rd_o),
    .req_valid_o (req_valid_o),
    .req_kind_o  (req_kind_o),
    .wr_busy_i   (wr_busy_i)
);

// File: tb/spi_mem_front_tb.sv
`timescale 1ns/1ps
module spi_mem_front_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic       so_o, so_oe_o, mem_rd_o, req_valid_o;
    logic [8:0] mem_addr_o, req_addr_o;
    logic [7:0] mem_rdata = 8'h00, status = 8'h00, req_data_o;
    logic [2:0] req_kind_o;
    logic       busy = 1'b0;

    int total = 0, bad = 0, idle_viol = 0, hold_viol = 0, rd_count = 0;
    int cs_hi_cnt = 0, hold_lo_cnt = 0;
    bit finished = 0;
    logic [7:0] mem [512];
    logic [2:0] qk [$];
    logic [8:0] qa [$];
    logic [7:0] qd [$];

    always #2 clk = ~clk;

    spi_mem_front u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .si_i(si),
        .hold_n_i(hold_n), .so_o(so_o), .so_oe_o(so_oe_o), .mem_rd_o(mem_rd_o),
        .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata), .status_i(status),
        .wr_busy_i(busy), .req_valid_o(req_valid_o), .req_kind_o(req_kind_o),
        .req_addr_o(req_addr_o), .req_data_o(req_data_o)
    );

    // Array model: synchronous read, one cycle of latency
    always @(posedge clk) begin
        if (mem_rd_o) begin
            mem_rdata <= mem[mem_addr_o];
            rd_count  <= rd_count + 1;
        end
        if (req_valid_o) begin
            qk.push_back(req_kind_o);
            qa.push_back(req_addr_o);
            qd.push_back(req_data_o);
        end
    end

    // Per-clock reference check of the drive enable against deselect and hold
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_hi_cnt >= 4 && so_oe_o) idle_viol++;
            if (hold_lo_cnt >= 4 && so_oe_o) hold_viol++;
            cs_hi_cnt   = cs_n ? cs_hi_cnt + 1 : 0;
            hold_lo_cnt = !hold_n ? hold_lo_cnt + 1 : 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin(input bit mode3);
        sck = mode3; w(8); cs_n = 1'b0; w(8);
    endtask

    task automatic cs_end(input bit mode3);
        if (!mode3) begin sck = 1'b0; w(8); end
        cs_n = 1'b1; w(16);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit oe_all);
        oe_all = 1;
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si = tx[i]; w(8);
            rx[i] = so_o;
            if (!so_oe_o) oe_all = 0;
            sck = 1'b1; w(8);
        end
    endtask

    task automatic hold_pause(input string tag);
        sck = 1'b0; w(8);
        hold_n = 1'b0; w(6);
        chk(tag, so_oe_o, 1'b0);
        for (int k = 0; k < 3; k++) begin
            si = ~si; sck = 1'b1; w(8); sck = 1'b0; w(8);
        end
        hold_n = 1'b1; w(6);
    endtask

    task automatic read_seq(input bit mode3, input logic [7:0] op, input logic [7:0] a,
                            input int nb, input logic [8:0] start, input string tag, input bit pause);
        logic [7:0] rx; bit oe;
        cs_begin(mode3);
        xfer(op, rx, oe); xfer(a, rx, oe);
        for (int j = 0; j < nb; j++) begin
            if (pause && j == 1) hold_pause({tag, " hold hi-z"});
            xfer(8'hA5, rx, oe);
            chk(tag, rx, mem[9'(start + 9'(j))]);
            chk({tag, " drive"}, oe, 1'b1);
        end
        cs_end(mode3);
    endtask

    task automatic expect_req(input string tag, input logic [2:0] k, input logic [8:0] a,
                              input logic [7:0] d, input bit full);
        if (qk.size() == 0) begin
            chk({tag, " missing"}, 0, 1);
        end else begin
            chk({tag, " kind"}, qk.pop_front(), k);
            if (full) begin
                chk({tag, " addr"}, qa.pop_front(), a);
                chk({tag, " data"}, qd.pop_front(), d);
            end else begin
                void'(qa.pop_front()); void'(qd.pop_front());
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx; bit oe; int rd0;
        for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 4));
        w(5); rst_n = 1'b1; w(10);

        // Reset state
        chk("R5 reset oe", so_oe_o, 0);
        chk("R11 reset req", req_valid_o, 0);
        chk("R11 reset rd", mem_rd_o, 0);

        // R3 R2: mode 0 read from 0x005
        read_seq(0, 8'h03, 8'h05, 3, 9'h005, "R3 read mode0", 0);
        // R1 R3: bit 3 carries A8, wrap 0x1FF -> 0x000
        read_seq(0, 8'h0B, 8'hFE, 4, 9'h1FE, "R1 R3 wrap", 0);
        // R2: mode 3 (clock idles high)
        read_seq(1, 8'h0B, 8'h20, 2, 9'h120, "R2 read mode3", 0);
        // R6: hold in the middle of a read stream
        read_seq(0, 8'h03, 8'h40, 3, 9'h040, "R6 read hold", 1);

        // R8: status read repeats, recaptures each byte
        status = 8'h0C;
        cs_begin(0);
        xfer(8'h05, rx, oe);
        xfer(8'h00, rx, oe); chk("R8 status b1", rx, 8'h0C);
        xfer(8'h00, rx, oe); chk("R8 status b2", rx, 8'h0C);
        status = 8'h08;
        xfer(8'h00, rx, oe); chk("R8 status b3 old", rx, 8'h0C);
        xfer(8'h00, rx, oe); chk("R8 status b4 new", rx, 8'h08);
        cs_end(0);

        // R10 R1: latch commands, bit 3 ignored
        cs_begin(0); xfer(8'h0E, rx, oe); cs_end(0);
        expect_req("R10 R1 enable", 3'd1, 9'h0, 8'h0, 0);
        cs_begin(1); xfer(8'h04, rx, oe); cs_end(1);
        expect_req("R10 disable", 3'd2, 9'h0, 8'h0, 0);
        cs_begin(0); xfer(8'h01, rx, oe); xfer(8'h3C, rx, oe); xfer(8'h55, rx, oe); cs_end(0);
        expect_req("R10 status write", 3'd3, 9'h0, 8'h3C, 0);
        chk("R10 extra byte ignored", qk.size(), 0);
        if (qd.size() == 0) ;

        // R9 R6: page write with A8, hold with noise on SI
        cs_begin(0);
        xfer(8'h0A, rx, oe); xfer(8'hFE, rx, oe);
        xfer(8'h11, rx, oe);
        hold_pause("R6 write hold hi-z");
        xfer(8'h22, rx, oe); xfer(8'h33, rx, oe);
        cs_end(0);
        expect_req("R9 byte0", 3'd4, 9'h1FE, 8'h11, 1);
        expect_req("R9 R6 byte1", 3'd4, 9'h1FF, 8'h22, 1);
        expect_req("R9 page wrap", 3'd4, 9'h1F8, 8'h33, 1);

        // R4: invalid opcodes
        rd0 = rd_count;
        cs_begin(0); xfer(8'h83, rx, oe); xfer(8'h00, rx, oe); xfer(8'h00, rx, oe);
        chk("R4 upper bits hi-z", oe, 0); cs_end(0);
        cs_begin(0); xfer(8'h07, rx, oe); xfer(8'h06, rx, oe); xfer(8'h00, rx, oe);
        chk("R4 code 111 hi-z", oe, 0); cs_end(0);
        chk("R4 no request", qk.size(), 0);
        chk("R4 no read", rd_count - rd0, 0);
        read_seq(0, 8'h03, 8'h10, 1, 9'h010, "R4 recovery read", 0);

        // R7: busy
        busy = 1'b1; status = 8'hFF; w(4);
        rd0 = rd_count;
        cs_begin(0); xfer(8'h03, rx, oe); xfer(8'h00, rx, oe); xfer(8'h00, rx, oe);
        chk("R7 read blocked hi-z", oe, 0); cs_end(0);
        cs_begin(0); xfer(8'h06, rx, oe); cs_end(0);
        cs_begin(0); xfer(8'h02, rx, oe); xfer(8'h00, rx, oe); xfer(8'h99, rx, oe); cs_end(0);
        chk("R7 no request", qk.size(), 0);
        chk("R7 no read", rd_count - rd0, 0);
        cs_begin(0); xfer(8'h05, rx, oe); xfer(8'h00, rx, oe); cs_end(0);
        chk("R7 status allowed", rx, 8'hFF);
        busy = 1'b0; w(4);

        chk("R5 idle hi-z every clock", idle_viol, 0);
        chk("R6 hold hi-z every clock", hold_viol, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule